// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block shifts a single data element by a signed amount supplied with the element. A non-negative amount shifts left and a negative amount shifts right by its magnitude. The element may be 8, 16, 32 or 64 bits wide and sits in the low bits of a 64-bit bus. Three interpretations are offered. In signed mode the element is two's complement. In unsigned mode it is a plain binary number. In mixed mode a signed source yields an unsigned result.

Right shifts can round half up. Left shifts that overflow can saturate to the limits of the result type. Every saturating event sets a sticky flag, and the flag stays set until software-side logic pulses a clear input. One result is accepted per cycle. It is registered once and is qualified by an output valid.

Top module: `vss_lane_shifter`

## Requirements
- R1: A result appears on `out_elem` with `out_valid` high exactly one cycle after `in_valid` is high. `out_valid` is low one cycle after `in_valid` is low, and `out_elem` then holds its previous value.
- R2: `in_shift` is read as a signed 8-bit number from -128 to 127. Values of 0 or more shift left by that amount, and negative values shift right by the magnitude. `in_size` selects the element width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Input bits above the element width have no effect.
- R3: A right shift without rounding is arithmetic in signed mode and logical in the other modes. A magnitude at or beyond the element width gives all ones for a negative signed element and zero otherwise.
- R4: A right shift with rounding adds the last bit shifted out to the truncated result (round half up). In signed mode, a magnitude at or beyond the width gives 0. In unsigned mode, a magnitude greater than the width gives 0, and a magnitude equal to the width gives the element's top bit.
- R5: A left shift smaller than the width whose result still fits the result type returns the exact product and leaves the flag alone.
- R6: When a left shift overflows and `in_sat` is 1, the result is saturated and the flag is set. In signed mode the result is the largest value of the width for a non-negative element and the smallest for a negative one. Otherwise the result is all ones of the width.
- R7: When `in_sat` is 0, an overflowing left shift returns its low width bits, extended per R10, and the flag is never set.
- R8: A left shift by the width or more returns 0 when the element is zero or `in_sat` is 0. Otherwise it saturates as in R6.
- R9: In mixed mode (`in_mode`=2), a negative element with `in_sat`=1 returns 0 and sets the flag. Otherwise the element is treated as unsigned.
- R10: In signed mode (`in_mode`=0) the result is sign-extended from the element width to 64 bits. In unsigned (1), mixed (2) and code 3, which behaves as unsigned, it is zero-extended.
- R11: `out_sat` rises in the cycle after a saturating event and stays high until `sat_clr` is sampled high. An event in the same cycle as a clear wins. Reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_elem | input | 64 | Element, in the low bits for the selected width |
| in_shift | input | 8 | Signed shift amount |
| in_size | input | 2 | Element width select |
| in_mode | input | 2 | 0 signed, 1 unsigned, 2 signed-to-unsigned |
| in_round | input | 1 | Round enable for right shifts |
| in_sat | input | 1 | Saturation enable |
| sat_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_elem | output | 64 | Extended result |
| out_sat | output | 1 | Sticky saturation flag |

## Verification
The bench targets the extreme shift magnitudes: -128, exactly minus the width with and without rounding, and left shifts at and past the width. A wrong rounding limit in unsigned mode would return 0 where the top bit belongs, and a missing sign fill would turn a negative element into 0. It drives overflow cases in every mode with saturation on and off. Testing the fit by magnitude instead of by round trip would let most-negative results saturate by mistake, and a missing truncation would leak high bits. It also pairs clears with events in the same cycle, so a clear that wins would drop a saturation report.

// File: rtl/vss_pkg.sv
package vss_pkg;

   localparam int unsigned VSS_NSIZE = 4;

   typedef enum logic [1:0] {
      VSS_SIGNED       = 2'd0,
      VSS_UNSIGNED     = 2'd1,
      VSS_S2U          = 2'd2,
      VSS_UNSIGNED_ALT = 2'd3
   } vss_mode_e;

   // element width in bits for a size code
   function automatic logic [7:0] vss_elem_bits(input logic [1:0] size_sel);
      return 8'(8 << size_sel);
   endfunction

endpackage

// File: rtl/vss_prep.sv
module vss_prep
   import vss_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int EXT_W = DATA_W + 1,
   localparam int NSZ   = VSS_NSIZE
) (
   input  logic [DATA_W-1:0] elem_i,
   input  logic [1:0]        size_i,
   input  vss_mode_e         mode_i,
   input  logic              sat_en_i,
   output logic [EXT_W-1:0]  opnd_o,
   output logic              signed_o,
   output logic              force_zero_o
);

   logic [EXT_W-1:0] sx [NSZ];
   logic [EXT_W-1:0] zx [NSZ];
   logic             msb [NSZ];

   for (genvar g = 0; g < NSZ; g++) begin : g_size
      localparam int EW = 8 << g;
      assign msb[g] = elem_i[EW-1];
      assign sx[g]  = {{(EXT_W-EW){elem_i[EW-1]}}, elem_i[EW-1:0]};
      assign zx[g]  = {{(EXT_W-EW){1'b0}}, elem_i[EW-1:0]};
   end

   always_comb begin
      signed_o     = (mode_i == VSS_SIGNED);
      opnd_o       = signed_o ? sx[size_i] : zx[size_i];
      force_zero_o = (mode_i == VSS_S2U) && sat_en_i && msb[size_i];
   end

endmodule

// File: rtl/vss_right.sv
module vss_right #(
   parameter int DATA_W  = 64,
   parameter int SHIFT_W = 8,
   localparam int EXT_W  = DATA_W + 1
) (
   input  logic [EXT_W-1:0]  opnd_i,
   input  logic              signed_i,
   input  logic              round_i,
   input  logic [SHIFT_W:0]  mag_i,
   input  logic [SHIFT_W:0]  ebits_i,
   output logic [EXT_W-1:0]  res_o
);

   logic [SHIFT_W:0]        limit;
   logic signed [EXT_W-1:0] s_op;
   logic signed [EXT_W-1:0] pre;

   always_comb begin
      // unsigned rounding keeps one extra step before collapsing to zero
      limit = ebits_i + {{SHIFT_W{1'b0}}, (round_i & ~signed_i)};
      s_op  = $signed(opnd_i);
      pre   = s_op >>> (mag_i - 1'b1);
      if (mag_i >= limit) begin
         res_o = round_i ? '0 : {EXT_W{opnd_i[EXT_W-1]}};
      end else if (round_i) begin
         res_o = (pre >>> 1) + {{(EXT_W-1){1'b0}}, pre[0]};
      end else begin
         res_o = s_op >>> mag_i;
      end
   end

endmodule

// File: rtl/vss_left.sv
module vss_left
   import vss_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int SHIFT_W = 8,
   localparam int EXT_W  = DATA_W + 1,
   localparam int WORK_W = 2 * DATA_W + 1,
   localparam int NSZ    = VSS_NSIZE
) (
   input  logic [EXT_W-1:0]   opnd_i,
   input  logic               signed_i,
   input  logic               sat_i,
   input  logic [SHIFT_W-1:0] amt_i,
   input  logic [1:0]         size_i,
   input  logic [SHIFT_W:0]   ebits_i,
   output logic [EXT_W-1:0]   res_o,
   output logic               ovf_o
);

   logic [WORK_W-1:0] wide;
   logic [WORK_W-1:0] shifted;
   logic [WORK_W-1:0] tr_s  [NSZ];
   logic [WORK_W-1:0] tr_z  [NSZ];
   logic [EXT_W-1:0]  s_max [NSZ];
   logic [EXT_W-1:0]  s_min [NSZ];
   logic [EXT_W-1:0]  u_max [NSZ];

   assign wide    = {{(WORK_W-EXT_W){opnd_i[EXT_W-1]}}, opnd_i};
   assign shifted = wide << amt_i;

   for (genvar g = 0; g < NSZ; g++) begin : g_size
      localparam int EW = 8 << g;
      assign tr_s[g]  = {{(WORK_W-EW){shifted[EW-1]}}, shifted[EW-1:0]};
      assign tr_z[g]  = {{(WORK_W-EW){1'b0}}, shifted[EW-1:0]};
      assign s_max[g] = {{(EXT_W-EW+1){1'b0}}, {(EW-1){1'b1}}};
      assign s_min[g] = {{(EXT_W-EW+1){1'b1}}, {(EW-1){1'b0}}};
      assign u_max[g] = {{(EXT_W-EW){1'b0}}, {EW{1'b1}}};
   end

   logic [WORK_W-1:0] trunc;
   logic [EXT_W-1:0]  satv;
   logic              fits;
   logic              in_range;

   always_comb begin
      trunc    = signed_i ? tr_s[size_i] : tr_z[size_i];
      fits     = (trunc == shifted);
      in_range = ({1'b0, amt_i} < ebits_i);
      if (signed_i) satv = opnd_i[EXT_W-1] ? s_min[size_i] : s_max[size_i];
      else          satv = u_max[size_i];
      ovf_o = 1'b0;
      res_o = '0;
      if (in_range) begin
         if (fits || !sat_i) begin
            res_o = trunc[EXT_W-1:0];
         end else begin
            res_o = satv;
            ovf_o = 1'b1;
         end
      end else if (sat_i && (|opnd_i)) begin
         res_o = satv;
         ovf_o = 1'b1;
      end
   end

endmodule

// File: rtl/vss_lane_shifter.sv
module vss_lane_shifter
   import vss_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int SHIFT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_elem,
   input  logic [SHIFT_W-1:0] in_shift,
   input  logic [1:0]         in_size,
   input  logic [1:0]         in_mode,
   input  logic               in_round,
   input  logic               in_sat,
   input  logic               sat_clr,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_elem,
   output logic               out_sat
);

   localparam int EXT_W = DATA_W + 1;

   if (DATA_W != 64) begin : g_bad_width
      $error("vss_lane_shifter: DATA_W must be 64 to hold every size code");
   end
   if (SHIFT_W < 8 || (1 << (SHIFT_W - 1)) <= DATA_W) begin : g_bad_shift
      $error("vss_lane_shifter: SHIFT_W too narrow for the element width");
   end

   vss_mode_e mode;
   assign mode = vss_mode_e'(in_mode);

   logic                     go_right;
   logic signed [SHIFT_W:0]  amt_x;
   logic [SHIFT_W:0]         mag;
   logic [SHIFT_W:0]         ebits;

   always_comb begin
      go_right = in_shift[SHIFT_W-1];
      amt_x    = {in_shift[SHIFT_W-1], in_shift};
      mag      = go_right ? (SHIFT_W+1)'(-amt_x) : (SHIFT_W+1)'(amt_x);
      ebits    = (SHIFT_W+1)'(vss_elem_bits(in_size));
   end

   logic [EXT_W-1:0] opnd;
   logic             is_signed;
   logic             force_zero;

   vss_prep #(.DATA_W(DATA_W)) u_prep (
      .elem_i       (in_elem),
      .size_i       (in_size),
      .mode_i       (mode),
      .sat_en_i     (in_sat),
      .opnd_o       (opnd),
      .signed_o     (is_signed),
      .force_zero_o (force_zero)
   );

   logic [EXT_W-1:0] r_res;
   logic [EXT_W-1:0] l_res;
   logic             l_ovf;

   vss_right #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_right (
      .opnd_i   (opnd),
      .signed_i (is_signed),
      .round_i  (in_round),
      .mag_i    (mag),
      .ebits_i  (ebits),
      .res_o    (r_res)
   );

   vss_left #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_left (
      .opnd_i   (opnd),
      .signed_i (is_signed),
      .sat_i    (in_sat),
      .amt_i    (in_shift),
      .size_i   (in_size),
      .ebits_i  (ebits),
      .res_o    (l_res),
      .ovf_o    (l_ovf)
   );

   logic [EXT_W-1:0] res;
   logic             sat_evt;

   always_comb begin
      sat_evt = force_zero | (~go_right & l_ovf);
      if (force_zero)    res = '0;
      else if (go_right) res = r_res;
      else               res = l_res;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_elem  <= '0;
         out_sat   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_elem <= res[DATA_W-1:0];
         out_sat   <= (out_sat & ~sat_clr) | (in_valid & sat_evt);
      end
   end

endmodule

// File: rtl/vss_lane_shifter_chk.sv
module vss_lane_shifter_chk #(
   parameter int DATA_W  = 64,
   parameter int SHIFT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [DATA_W-1:0]  in_elem,
   input logic [SHIFT_W-1:0] in_shift,
   input logic [1:0]         in_size,
   input logic [1:0]         in_mode,
   input logic               in_round,
   input logic               in_sat,
   input logic               sat_clr,
   input logic               out_valid,
   input logic [DATA_W-1:0]  out_elem,
   input logic               out_sat
);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_elem)));

   assert_min_shift_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd0 && !in_round && in_size == 2'd3 &&
       in_shift[SHIFT_W-1] && in_shift[SHIFT_W-2:0] == '0)
      |=> (out_elem == {DATA_W{$past(in_elem[DATA_W-1])}}));

   assert_no_flag_without_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_sat && !(in_valid && in_sat)) |=> !out_sat);

   assert_mixed_negative_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd2 && in_sat && in_size == 2'd0 && in_elem[7])
      |=> (out_elem == '0 && out_sat));

   assert_unsigned_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd1 && in_size == 2'd0)
      |=> (out_elem[DATA_W-1:8] == '0));

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sat && !sat_clr) |=> out_sat);

   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !in_valid) |=> !out_sat);

endmodule

bind vss_lane_shifter vss_lane_shifter_chk #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_elem   (in_elem),
   .in_shift  (in_shift),
   .in_size   (in_size),
   .in_mode   (in_mode),
   .in_round  (in_round),
   .in_sat    (in_sat),
   .sat_clr   (sat_clr),
   .out_valid (out_valid),
   .out_elem  (out_elem),
   .out_sat   (out_sat)
);

// File: tb/vss_lane_shifter_tb.sv
module vss_lane_shifter_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_elem = '0;
   logic [7:0]  in_shift = '0;
   logic [1:0]  in_size = '0;
   logic [1:0]  in_mode = '0;
   logic        in_round = 1'b0;
   logic        in_sat = 1'b0;
   logic        sat_clr = 1'b0;
   logic        out_valid;
   logic [63:0] out_elem;
   logic        out_sat;

   always #(CLK_PERIOD/2) clk = ~clk;

   vss_lane_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_elem(in_elem),
      .in_shift(in_shift), .in_size(in_size), .in_mode(in_mode),
      .in_round(in_round), .in_sat(in_sat), .sat_clr(sat_clr),
      .out_valid(out_valid), .out_elem(out_elem), .out_sat(out_sat)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   logic  exp_valid = 1'b0;
   logic  [63:0] exp_elem = '0;
   logic  exp_flag = 1'b0;
   string exp_tag = "R1";

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // behavioural model: wide integer arithmetic, range tests for overflow
   function automatic void model(input logic [63:0] d, input logic [7:0] sh, input logic [1:0] sz,
                                 input logic [1:0] md, input logic rnd, input logic st,
                                 output logic [63:0] res, output logic ev);
      int w;
      int n;
      logic sgn;
      logic signed [199:0] x, v, lo, hi, one;
      w = 8 << sz;
      sgn = (md == 2'd0);
      one = 1;
      ev = 1'b0;
      x = '0;
      res = '0;
      for (int i = 0; i < w; i++) x[i] = d[i];
      if (sgn && d[w-1]) for (int i = w; i < 200; i++) x[i] = 1'b1;
      n = int'($signed(sh));
      if (md == 2'd2 && st && d[w-1]) begin
         ev = 1'b1;
         return;
      end
      if (n < 0) begin
         if (rnd) v = (x + (one <<< (-n - 1))) >>> (-n);
         else     v = x >>> (-n);
      end else begin
         v = x <<< n;
         if (sgn) begin
            lo = -(one <<< (w - 1));
            hi = (one <<< (w - 1)) - one;
         end else begin
            lo = '0;
            hi = (one <<< w) - one;
         end
         if ((v < lo || v > hi) && st) begin
            ev = 1'b1;
            v = (sgn && x < 0) ? lo : hi;
         end
      end
      for (int i = 0; i < 64; i++) res[i] = (i < w) ? v[i] : (sgn ? v[w-1] : 1'b0);
   endfunction

   task automatic step(input logic v, input logic [63:0] d, input logic [7:0] sh,
                       input logic [1:0] sz, input logic [1:0] md, input logic rnd,
                       input logic st, input logic clr, input string tag);
      logic [63:0] r;
      logic ev;
      @(negedge clk);
      chk(exp_tag, "out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
      chk(exp_tag, "out_elem", out_elem, exp_elem);
      chk(exp_tag, "out_sat", {63'd0, out_sat}, {63'd0, exp_flag});
      in_valid = v; in_elem = d; in_shift = sh; in_size = sz; in_mode = md;
      in_round = rnd; in_sat = st; sat_clr = clr;
      model(d, sh, sz, md, rnd, st, r, ev);
      exp_valid = v;
      if (v) exp_elem = r;
      exp_flag = (exp_flag & ~clr) | (v & ev);
      exp_tag = tag;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "reset out_sat", {63'd0, out_sat}, 64'd0);
      chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R1", "reset out_elem", out_elem, 64'd0);

      // R7 wrap, then R6 saturate, R5 exact
      step(1, 64'h40, 8'd1, 2'd0, 2'd0, 0, 0, 0, "R7");
      step(1, 64'h40, 8'd1, 2'd0, 2'd0, 0, 1, 0, "R6");
      step(1, 64'hFD, 8'd1, 2'd0, 2'd0, 0, 1, 1, "R5");
      step(1, 64'h80, 8'd0, 2'd0, 2'd0, 0, 1, 0, "R5");
      // R4 rounding right shifts, signed
      step(1, 64'h80, 8'hFF, 2'd0, 2'd0, 1, 0, 0, "R4");
      step(1, 64'h81, 8'hFF, 2'd0, 2'd0, 1, 0, 0, "R4");
      step(1, 64'h7F, 8'hF9, 2'd0, 2'd0, 1, 0, 0, "R4");
      // R3 fill and R4 zero at exactly minus the width
      step(1, 64'h85, 8'hF8, 2'd0, 2'd0, 0, 0, 0, "R3");
      step(1, 64'h85, 8'hF8, 2'd0, 2'd0, 1, 0, 0, "R4");
      step(1, 64'hC0, 8'hF8, 2'd0, 2'd1, 1, 0, 0, "R4");
      step(1, 64'hC0, 8'hF7, 2'd0, 2'd1, 1, 0, 0, "R4");
      step(1, 64'hC0, 8'hF8, 2'd0, 2'd1, 0, 0, 0, "R3");
      step(1, 64'hFEDC, 8'hFC, 2'd1, 2'd1, 0, 0, 0, "R3");
      // R6 unsigned
      step(1, 64'h8001, 8'd1, 2'd1, 2'd1, 0, 1, 1, "R6");
      step(1, 64'h8001, 8'd1, 2'd1, 2'd1, 0, 0, 0, "R7");
      // R8 at and beyond the width
      step(1, 64'h5, 8'd40, 2'd2, 2'd0, 0, 1, 1, "R8");
      step(1, 64'hFFFF_FFFB, 8'd32, 2'd2, 2'd0, 0, 1, 1, "R8");
      step(1, 64'h0, 8'd40, 2'd2, 2'd0, 0, 1, 1, "R8");
      step(1, 64'hFFFF_FFFB, 8'd40, 2'd2, 2'd0, 0, 0, 0, "R8");
      step(1, 64'h1, 8'd127, 2'd3, 2'd1, 0, 1, 1, "R8");
      // R9 mixed mode
      step(1, 64'h90, 8'd0, 2'd0, 2'd2, 0, 1, 1, "R9");
      step(1, 64'h90, 8'hFC, 2'd0, 2'd2, 0, 0, 1, "R9");
      step(1, 64'h7F, 8'd1, 2'd0, 2'd2, 0, 1, 1, "R9");
      step(1, 64'h8000_0000, 8'd1, 2'd2, 2'd2, 0, 0, 1, "R9");
      // R11 clear alone, then clear with an event
      step(0, 64'h0, 8'd0, 2'd0, 2'd0, 0, 0, 1, "R11");
      step(0, 64'h0, 8'd0, 2'd0, 2'd0, 0, 0, 0, "R11");
      step(1, 64'h40, 8'd2, 2'd0, 2'd0, 0, 1, 1, "R11");
      step(0, 64'h0, 8'd0, 2'd0, 2'd0, 0, 0, 0, "R11");
      // R2 upper bits ignored, extreme shift codes; R10 extension
      step(1, 64'hABCD_EF01_2345_6712, 8'd0, 2'd0, 2'd1, 0, 0, 0, "R2");
      step(1, 64'hABCD_EF01_2345_6792, 8'd0, 2'd0, 2'd0, 0, 0, 0, "R10");
      step(1, 64'h8000_0000_0000_0001, 8'h80, 2'd3, 2'd0, 0, 0, 0, "R2");
      step(1, 64'h8000_0000_0000_0001, 8'h80, 2'd3, 2'd0, 1, 0, 0, "R2");
      step(1, 64'hFFFF_0000_0000_00F0, 8'h81, 2'd3, 2'd1, 1, 0, 0, "R2");
      step(1, 64'hFF80, 8'd0, 2'd1, 2'd3, 0, 0, 0, "R10");
      // R1 idle cycles hold the result
      step(0, 64'h1234, 8'd3, 2'd1, 2'd1, 0, 0, 0, "R1");
      step(0, 64'h5678, 8'd3, 2'd1, 2'd1, 0, 0, 1, "R1");

      for (int k = 0; k < 3000; k++) begin
         logic [63:0] d;
         logic [7:0] sh;
         d = {$urandom, $urandom};
         case ($urandom_range(0, 3))
            0: sh = 8'($urandom_range(0, 70));
            1: sh = 8'(-$urandom_range(1, 70));
            default: sh = 8'($urandom);
         endcase
         step(($urandom_range(0, 4) != 0), d, sh, 2'($urandom), 2'($urandom),
              1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), "R10");
      end
      step(0, 64'h0, 8'd0, 2'd0, 2'd0, 0, 0, 0, "R1");
      step(0, 64'h0, 8'd0, 2'd0, 2'd0, 0, 0, 0, "R1");
      finish_run();
   end

endmodule